// File: doc/BRIEF.md
# Ethernet Receive Byte-to-Word Framer

This block takes the byte-wide receive stream of a gigabit physical interface (one byte per clock, qualified by a data-valid strobe). It finds the start of each frame, discards the preamble and start-of-frame delimiter, and packs the frame bytes into 32-bit words. Each word goes to a downstream FIFO write port as a one-cycle write strobe, with a 2-bit command code and a 2-bit byte count. The FIFO itself, and any clock crossing, sit outside the block.

Words move on as soon as they are complete. The frame check sequence is therefore known only after most of the frame has left the block. The CRC-32 verdict is carried by the command code of the last word alone: a good frame ends with an end-of-packet code and a bad one with an invalid-frame code. No data is held back or removed.

A write attempted while the FIFO reports full is dropped. That frame is then marked invalid, and a saturating overflow counter advances.

The controlling state machine has four states:
- `ST_IDLE` waits for valid.
- `ST_PREAMBLE` consumes 0x55 bytes.
- `ST_BODY` packs frame bytes.
- `ST_DISCARD` swallows a malformed start until valid drops.

Its transitions are:
- IDLE→PREAMBLE on a valid 0x55.
- IDLE→DISCARD on any other valid byte.
- PREAMBLE→PREAMBLE on 0x55.
- PREAMBLE→BODY on 0xD5.
- PREAMBLE→DISCARD on any other byte.
- PREAMBLE→IDLE when valid drops.
- BODY→IDLE when valid drops; this is where the last word is flushed.
- DISCARD→IDLE when valid drops.

Top module: `eth_rx_packer`

## Requirements
- R1: After reset `wr_en` is 0 and `ovf_count` is 0.
- R2: A frame starts only when the byte 0xD5 follows one or more 0x55 bytes, all with valid high. No preamble or delimiter byte appears in any written word, whatever the preamble length.
- R3: Frame bytes are packed in arrival order: the first byte of each word goes to `wr_data[7:0]`, the second to `[15:8]`, the third to `[23:16]` and the fourth to `[31:24]`. Unused lanes of a partial final word are zero.
- R4: `wr_cmd` is coded as follows:
  - 0 marks the first word of a frame that is not its last.
  - 1 marks a later word that is not the last.
  - 2 marks the last word of a good frame.
  - 3 marks the last word of a bad frame.
- R5: `wr_cnt` is 0 on every non-final word. On the final word it is the number of valid bytes modulo 4, with 0 meaning four. A partially filled word is still written when valid falls.
- R6: The CRC-32 uses the reflected polynomial 0xEDB88320 and a 0xFFFFFFFF seed, and runs over every frame byte including the FCS. The frame is good when the register equals 0xDEBB20E3 after the last byte; any other value yields code 3.
- R7: A valid byte other than 0x55 or 0xD5 before the delimiter, or a 0xD5 with no preceding 0x55, aborts the frame. Nothing is written until valid has dropped and a new preamble begins.
- R8: A completed word is written (`wr_en` high for one cycle) in the clock after the edge that samples the byte following its fourth byte. The final word is written in the clock after the edge that samples valid low.
- R9: If `fifo_full` is high at the edge where a write is due, `wr_en` stays low, `ovf_count` increases by one (saturating), and the frame's final word carries code 3 even if its CRC is good.
- R10: A frame whose valid drops directly after the delimiter writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_dv | input | 1 | Byte valid from the physical interface |
| rx_byte | input | 8 | Received byte |
| fifo_full | input | 1 | Downstream FIFO cannot accept a word |
| wr_en | output | 1 | One-cycle write strobe |
| wr_data | output | 32 | Packed frame word |
| wr_cmd | output | 2 | Command code of the word |
| wr_cnt | output | 2 | Valid byte count of the final word (0 means four) |
| ovf_count | output | 8 | Saturating count of dropped writes |

## Verification
The hardest situation to reach is a dropped mid-frame write followed by a frame that still ends cleanly. It needs `fifo_full` high on exactly the edge where a completed word is due, and low on every other edge. The bench raises `fifo_full` in the same half-cycle it drives the fifth frame byte, which is the byte whose sampling releases the first word. The bench then confirms three things: that word is missing, the counter advanced by one, and the otherwise good frame ends with code 3. The final-word timing and the partial-word flush are checked by recording the cycle of each write against the cycle in which valid was released.

// File: rtl/rx_pack_pkg.sv
package rx_pack_pkg;

    typedef enum logic [1:0] {
        CMD_SOP  = 2'd0,
        CMD_DATA = 2'd1,
        CMD_EOP  = 2'd2,
        CMD_BAD  = 2'd3
    } rx_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_BODY,
        ST_DISCARD
    } rx_state_e;

    localparam logic [7:0]  PRE_BYTE    = 8'h55;
    localparam logic [7:0]  SFD_BYTE    = 8'hD5;
    localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED    = 32'hFFFFFFFF;
    localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

endpackage

// File: rtl/rx_crc32.sv
module rx_crc32
    import rx_pack_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        seed_i,
    input  logic        step_i,
    input  logic [7:0]  byte_i,
    output logic [31:0] crc_o
);

    // Bit-serial update unrolled over one byte, LSB first
    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'd0, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

    logic [31:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (seed_i) begin
            crc_q <= CRC_SEED;
        end else if (step_i) begin
            crc_q <= crc_byte(crc_q, byte_i);
        end
    end

    assign crc_o = crc_q;

    // The register is reloaded with the seed whenever a frame starts (R6)
    assert_seed_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seed_i |=> crc_q == CRC_SEED);

endmodule

// File: rtl/rx_word_pack.sv
module rx_word_pack #(
    parameter int WORD_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear_i,
    input  logic                   load_i,
    input  logic [7:0]             byte_i,
    output logic [8*WORD_BYTES-1:0] word_o,
    output logic [$clog2(WORD_BYTES+1)-1:0] fill_o
);

    localparam int FILL_W = $clog2(WORD_BYTES + 1);

    logic [FILL_W-1:0] fill_q;
    logic              wrap;

    // A load into a full word starts a fresh word in lane 0
    assign wrap = (fill_q == FILL_W'(WORD_BYTES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (clear_i) begin
            fill_q <= '0;
        end else if (load_i) begin
            fill_q <= wrap ? FILL_W'(1) : fill_q + FILL_W'(1);
        end
    end

    for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
        logic [7:0] lane_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (clear_i) begin
                lane_q <= '0;
            end else if (load_i) begin
                if (wrap) begin
                    lane_q <= (l == 0) ? byte_i : 8'd0;
                end else if (fill_q == FILL_W'(l)) begin
                    lane_q <= byte_i;
                end
            end
        end
        assign word_o[8*l +: 8] = lane_q;
    end

    assign fill_o = fill_q;

    assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= FILL_W'(WORD_BYTES));

endmodule

// File: rtl/eth_rx_packer.sv
module eth_rx_packer
    import rx_pack_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    parameter int OVF_W      = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rx_dv,
    input  logic [7:0]                     rx_byte,
    input  logic                           fifo_full,
    output logic                           wr_en,
    output logic [8*WORD_BYTES-1:0]        wr_data,
    output logic [1:0]                     wr_cmd,
    output logic [$clog2(WORD_BYTES)-1:0]  wr_cnt,
    output logic [OVF_W-1:0]               ovf_count
);

    localparam int WORD_W = 8 * WORD_BYTES;
    localparam int FILL_W = $clog2(WORD_BYTES + 1);
    localparam int CNT_W  = $clog2(WORD_BYTES);

    rx_state_e         state_q, state_d;
    logic [WORD_W-1:0] word;
    logic [FILL_W-1:0] fill;
    logic [31:0]       crc;
    logic              first_q, lost_q;
    logic              sfd_hit, byte_in, frame_end;
    logic              mid_push, end_push, push_req;

    assign sfd_hit   = (state_q == ST_PREAMBLE) && rx_dv && (rx_byte == SFD_BYTE);
    assign byte_in   = (state_q == ST_BODY) && rx_dv;
    assign frame_end = (state_q == ST_BODY) && !rx_dv;
    assign mid_push  = byte_in && (fill == FILL_W'(WORD_BYTES));
    assign end_push  = frame_end && (fill != '0);
    assign push_req  = mid_push || end_push;

    rx_crc32 u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .seed_i (sfd_hit),
        .step_i (byte_in),
        .byte_i (rx_byte),
        .crc_o  (crc)
    );

    rx_word_pack #(.WORD_BYTES(WORD_BYTES)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (sfd_hit),
        .load_i  (byte_in),
        .byte_i  (rx_byte),
        .word_o  (word),
        .fill_o  (fill)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rx_dv) state_d = (rx_byte == PRE_BYTE) ? ST_PREAMBLE : ST_DISCARD;
            end
            ST_PREAMBLE: begin
                if (!rx_dv)                    state_d = ST_IDLE;
                else if (rx_byte == SFD_BYTE)  state_d = ST_BODY;
                else if (rx_byte != PRE_BYTE)  state_d = ST_DISCARD;
            end
            ST_BODY: begin
                if (!rx_dv) state_d = ST_IDLE;
            end
            ST_DISCARD: begin
                if (!rx_dv) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Frame bookkeeping and write port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q   <= 1'b0;
            lost_q    <= 1'b0;
            wr_en     <= 1'b0;
            wr_data   <= '0;
            wr_cmd    <= CMD_SOP;
            wr_cnt    <= '0;
            ovf_count <= '0;
        end else begin
            wr_en <= push_req && !fifo_full;
            if (sfd_hit) begin
                first_q <= 1'b1;
                lost_q  <= 1'b0;
            end else begin
                if (mid_push)              first_q <= 1'b0;
                if (push_req && fifo_full) lost_q  <= 1'b1;
            end
            if (push_req && fifo_full && (ovf_count != '1)) begin
                ovf_count <= ovf_count + OVF_W'(1);
            end
            if (push_req) begin
                wr_data <= word;
                if (end_push) begin
                    wr_cmd <= ((crc != CRC_RESIDUE) || lost_q) ? CMD_BAD : CMD_EOP;
                    wr_cnt <= fill[CNT_W-1:0];
                end else begin
                    wr_cmd <= first_q ? CMD_SOP : CMD_DATA;
                    wr_cnt <= '0;
                end
            end
        end
    end

    assert_push_from_body_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(state_q) == ST_BODY);

    assert_no_write_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$past(fifo_full));

    assert_ovf_single_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_count - $past(ovf_count)) <= OVF_W'(1));

    assert_nonfinal_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_cmd == CMD_SOP || wr_cmd == CMD_DATA)) |-> wr_cnt == '0);

    assert_discard_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DISCARD) |=> !wr_en);

endmodule

// File: tb/test_eth_rx_packer.sv
module test_eth_rx_packer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_dv = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        fifo_full = 1'b0;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [1:0]  wr_cmd;
    logic [1:0]  wr_cnt;
    logic [7:0]  ovf_count;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    logic [7:0]  tx [0:299];
    int          tx_n;
    int          fstart;
    logic [7:0]  fb [0:299];
    int          fl;

    logic [31:0] cap_data [0:127];
    logic [1:0]  cap_cmd  [0:127];
    logic [1:0]  cap_cnt  [0:127];
    int          cap_cyc  [0:127];
    int          cap_n = 0;
    int          fall_cyc;
    int          b4_cyc;
    int          exp_ovf = 0;

    eth_rx_packer i_eth_rx_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_dv     (rx_dv),
        .rx_byte   (rx_byte),
        .fifo_full (fifo_full),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wr_cmd    (wr_cmd),
        .wr_cnt    (wr_cnt),
        .ovf_count (ovf_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && wr_en && cap_n < 128) begin
            cap_data[cap_n] = wr_data;
            cap_cmd[cap_n]  = wr_cmd;
            cap_cnt[cap_n]  = wr_cnt;
            cap_cyc[cap_n]  = cyc;
            cap_n++;
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc == 150000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Preamble of npre bytes, delimiter, payload, FCS (low byte first)
    task automatic build_frame(input int npre, input int plen, input int seed, input bit corrupt);
        logic [31:0] c;
        tx_n = 0;
        for (int k = 0; k < npre; k++) begin tx[tx_n] = 8'h55; tx_n++; end
        tx[tx_n] = 8'hD5; tx_n++;
        fstart = tx_n;
        c = 32'hFFFFFFFF;
        for (int k = 0; k < plen; k++) begin
            fb[k] = 8'((seed + k * 37 + (k >> 3)) & 255);
            c = c ^ {24'd0, fb[k]};
            for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        c = ~c;
        for (int k = 0; k < 4; k++) fb[plen + k] = c[8*k +: 8];
        fl = plen + 4;
        if (corrupt) fb[2] = fb[2] ^ 8'h01;
        for (int k = 0; k < fl; k++) begin tx[tx_n] = fb[k]; tx_n++; end
    endtask

    // Drive tx[0..tx_n-1]; full_pos raises fifo_full while that stream byte is driven
    task automatic send(input int full_pos);
        cap_n = 0;
        b4_cyc = -1;
        for (int k = 0; k < tx_n; k++) begin
            @(negedge clk);
            rx_dv = 1'b1;
            rx_byte = tx[k];
            fifo_full = (k == full_pos);
            if (k == fstart + 4) b4_cyc = cyc + 1;
        end
        @(negedge clk);
        rx_dv = 1'b0;
        rx_byte = 8'h00;
        fifo_full = 1'b0;
        fall_cyc = cyc + 1;
        repeat (10) @(negedge clk);
    endtask

    task automatic check_frame(input string req, input bit bad, input int drop_first);
        int nw;
        bit ok_data, ok_cmd, ok_cnt;
        logic [31:0] ew;
        int ec, en;
        nw = (fl + 3) / 4;
        chk(cap_n == nw - drop_first, {req, " word count"}, cap_n, nw - drop_first);
        ok_data = 1; ok_cmd = 1; ok_cnt = 1;
        for (int k = 0; k < cap_n && k < nw - drop_first; k++) begin
            int i;
            i = k + drop_first;
            for (int l = 0; l < 4; l++) ew[8*l +: 8] = (i*4 + l < fl) ? fb[i*4 + l] : 8'h00;
            ec = (i == nw - 1) ? (bad ? 3 : 2) : (i == 0 ? 0 : 1);
            en = (i == nw - 1) ? (fl % 4) : 0;
            if (cap_data[k] !== ew) begin
                ok_data = 0;
                $display("FAIL R3 %s word %0d data: actual=%h expected=%h", req, i, cap_data[k], ew);
            end
            if (cap_cmd[k] !== 2'(ec)) begin
                ok_cmd = 0;
                $display("FAIL R4 %s word %0d cmd: actual=%0d expected=%0d", req, i, cap_cmd[k], ec);
            end
            if (cap_cnt[k] !== 2'(en)) begin
                ok_cnt = 0;
                $display("FAIL R5 %s word %0d cnt: actual=%0d expected=%0d", req, i, cap_cnt[k], en);
            end
        end
        tests += 3;
        if (!ok_data) fails++;
        if (!ok_cmd)  fails++;
        if (!ok_cnt)  fails++;
    endtask

    task automatic t_reset();
        // R1
        chk(wr_en == 1'b0, "R1 wr_en after reset", wr_en, 0);
        chk(ovf_count == 8'd0, "R1 ovf_count after reset", ovf_count, 0);
    endtask

    task automatic t_lengths();
        // R3 R4 R5 R6: final words holding four, one, two and three bytes
        for (int p = 60; p < 64; p++) begin
            build_frame(7, p, p * 3, 1'b0);
            send(-1);
            check_frame("R6 good frame", 1'b0, 0);
        end
    endtask

    task automatic t_short_preamble();
        // R2: a single 0x55 before the delimiter
        build_frame(1, 10, 99, 1'b0);
        send(-1);
        check_frame("R2 one-byte preamble", 1'b0, 0);
        chk(cap_n > 0 && cap_data[0][7:0] == fb[0], "R2 first lane is first frame byte",
            cap_data[0][7:0], fb[0]);
    endtask

    task automatic t_timing();
        // R8: first word after fifth byte sampled, final word after valid low
        build_frame(7, 21, 5, 1'b0);
        send(-1);
        chk(cap_n > 0 && cap_cyc[0] == b4_cyc, "R8 first write cycle", cap_cyc[0], b4_cyc);
        chk(cap_n > 0 && cap_cyc[cap_n-1] == fall_cyc, "R8 final write cycle",
            cap_cyc[cap_n-1], fall_cyc);
    endtask

    task automatic t_corrupt();
        // R6: one flipped bit gives code 3
        build_frame(7, 40, 17, 1'b1);
        send(-1);
        check_frame("R6 corrupted frame", 1'b1, 0);
    endtask

    task automatic t_abort();
        // R7: foreign byte inside preamble
        tx_n = 0;
        tx[0] = 8'h55; tx[1] = 8'h55; tx[2] = 8'h12;
        for (int k = 3; k < 30; k++) tx[k] = 8'(k * 11);
        tx_n = 30;
        fstart = 3;
        send(-1);
        chk(cap_n == 0, "R7 bad preamble byte writes nothing", cap_n, 0);
        // R7: delimiter with no preceding preamble
        tx[0] = 8'hD5;
        for (int k = 1; k < 20; k++) tx[k] = 8'(k * 7);
        tx_n = 20;
        fstart = 1;
        send(-1);
        chk(cap_n == 0, "R7 bare delimiter writes nothing", cap_n, 0);
        // R7: next proper frame is still received
        build_frame(3, 12, 44, 1'b0);
        send(-1);
        check_frame("R7 frame after abort", 1'b0, 0);
    endtask

    task automatic t_empty();
        // R10
        tx[0] = 8'h55; tx[1] = 8'hD5;
        tx_n = 2;
        fstart = 2;
        send(-1);
        chk(cap_n == 0, "R10 empty frame writes nothing", cap_n, 0);
    endtask

    task automatic t_overflow();
        // R9: full on the edge releasing the first word
        build_frame(7, 30, 61, 1'b0);
        send(fstart + 4);
        exp_ovf++;
        check_frame("R9 frame with dropped word", 1'b1, 1);
        chk(ovf_count == 8'(exp_ovf), "R9 ovf_count after drop", ovf_count, exp_ovf);
        // the following frame is clean again and leaves the counter alone
        build_frame(7, 16, 8, 1'b0);
        send(-1);
        check_frame("R9 frame after overflow", 1'b0, 0);
        chk(ovf_count == 8'(exp_ovf), "R9 ovf_count unchanged", ovf_count, exp_ovf);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_lengths();
        t_short_preamble();
        t_timing();
        t_corrupt();
        t_abort();
        t_empty();
        t_overflow();
        summary();
    end

endmodule